// File: doc/BRIEF.md
# Standby entry and wake-up controller

This block puts a small processor subsystem into a deep-standby state and brings it back out. When the CPU issues a sleep request while the standby-enable bit is set, the block gates off the system clock enable and then turns off the oscillator enable. With the bit clear, the same request yields only an ordinary sleep indication and the clock keeps running.

While in standby, the block watches two pins: a non-maskable interrupt pin and an external interrupt pin. Both pass through a synchronizer and an edge detector that run on a free-running always-on clock. A wake edge of the configured polarity turns the oscillator enable back on at once. The system clock stays gated while a prescaled 8-bit stabilization counter runs to overflow. The counter's interval must be chosen longer than the oscillator settling time. On overflow the clock enable returns and a one-cycle wake interrupt names the pin that caused the wake.

Configuration arrives through a simple write port with three registers. Level sensing on the external pin is never a wake source.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, clk_en and osc_en are 1 and wake_irq and nap_pulse are 0. The reset values are: standby enable 0, non-maskable edge select 0, external mode 00, clock select 0.
- R2: A sleep_req sampled in the running state with standby enable set drives clk_en to 0 in the next cycle, while osc_en stays 1. osc_en drops to 0 one cycle after that.
- R3: A sleep_req with standby enable clear gives a one-cycle nap_pulse in the next cycle, and clk_en and osc_en stay 1.
- R4: The non-maskable edge select is 0 for a falling edge and 1 for a rising edge. In standby, only the selected edge on nmi_pin wakes the block. The opposite edge leaves osc_en at 0.
- R5: The external mode codes are 01 for a falling edge, 10 for a rising edge, 11 for both edges and 00 for level. In standby, a matching edge on ext_pin wakes the block. Mode 00, or a non-matching edge, never wakes it.
- R6: osc_en returns to 1 three cycles after a qualifying pin change: two synchronizer stages plus the edge compare. clk_en stays 0 at that point.
- R7: Stabilization lasts exactly 256 × 2^(S+1) cycles, where S is the clock-select value (divide ratios 2 to 256). clk_en stays 0 until the overflow, and returns to 1 at the overflow.
- R8: wake_irq is a one-cycle pulse in the first cycle with clk_en back at 1. wake_src is 0 for the non-maskable pin and 1 for the external pin. The non-maskable pin wins when both pins wake the block in the same cycle.
- R9: The stabilization counter is cleared on every entry to standby, so back-to-back standby periods have identical length.
- R10: The write port decodes three addresses. Address 0, bit 0 is standby enable. Address 1, bit 0 is the non-maskable edge select and bits 2:1 are the external mode. Address 2, bits 2:0 are the clock select. A write to address 3 changes nothing.
- R11: Pin edges while the block is running produce no wake_irq and leave clk_en and osc_en at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Write data |
| sleep_req | input | 1 | Sleep request from the CPU |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin |
| ext_pin | input | 1 | Raw external interrupt pin |
| clk_en | output | 1 | System clock enable (0 = gated) |
| osc_en | output | 1 | Oscillator enable |
| nap_pulse | output | 1 | One-cycle indication of ordinary sleep |
| wake_irq | output | 1 | One-cycle wake interrupt |
| wake_src | output | 1 | Wake source: 0 non-maskable pin, 1 external pin |

## Verification
Each output has a fixed arrival time after its stimulus:
- nap_pulse and the clock gate are due one cycle after sleep_req.
- osc_en falls one cycle after that.
- After a pin change, osc_en rises on the third cycle.
- clk_en, wake_irq and wake_src arrive 256 × 2^(S+1) cycles after osc_en rises.

The bench drives inputs on the falling clock edge and counts whole cycles from that point. It samples each output on the falling edge of its due cycle, and also on the falling edge just before it, so that an output that comes one cycle early or one cycle late is caught.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_ENTER   = 2'd1,
    ST_STANDBY = 2'd2,
    ST_STAB    = 2'd3
  } stby_state_e;

  typedef enum logic [1:0] {
    EXT_LEVEL = 2'b00,
    EXT_FALL  = 2'b01,
    EXT_RISE  = 2'b10,
    EXT_BOTH  = 2'b11
  } ext_mode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_EDGE  = 2'd1;
  localparam logic [1:0] ADDR_TIMER = 2'd2;

  // prescaler divide ratio for a clock-select value: 2, 4, 8, ...
  function automatic int unsigned prescale_div(input int unsigned sel);
    return 32'd2 << sel;
  endfunction

  // full stabilization interval in clock cycles
  function automatic int unsigned stab_cycles(input int unsigned sel,
                                              input int unsigned cnt_w);
    return (32'd1 << cnt_w) * prescale_div(sel);
  endfunction

  // does an external-pin edge match the configured wake mode
  function automatic logic ext_edge_match(input ext_mode_e mode,
                                          input logic rise, input logic fall);
    case (mode)
      EXT_FALL: return fall;
      EXT_RISE: return rise;
      EXT_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/stby_pin_sync.sv
module stby_pin_sync #(
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] rise_o,
  output logic [N_PINS-1:0] fall_o
);

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic                   sync_w;

    assign sync_w = chain_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], pins_i[p]};
        prev_q  <= sync_w;
      end
    end

    assign rise_o[p] = sync_w & ~prev_q;
    assign fall_o[p] = ~sync_w & prev_q;
  end

endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual
  import stby_pkg::*;
(
  input  logic      armed,
  input  logic      nmi_sel,
  input  logic      nmi_rise,
  input  logic      nmi_fall,
  input  ext_mode_e ext_mode,
  input  logic      ext_rise,
  input  logic      ext_fall,
  output logic      nmi_hit,
  output logic      ext_hit,
  output logic      wake_hit,
  output logic      wake_from_ext
);

  always_comb begin
    nmi_hit       = armed && (nmi_sel ? nmi_rise : nmi_fall);
    ext_hit       = armed && ext_edge_match(ext_mode, ext_rise, ext_fall);
    wake_hit      = nmi_hit || ext_hit;
    wake_from_ext = ext_hit && !nmi_hit;
  end

endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer
  import stby_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done,
  output logic             is_zero
);

  localparam int PS_W = 1 << SEL_W;

  logic [PS_W-1:0]  pre_q;
  logic [PS_W-1:0]  pre_last;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_wrap;

  assign pre_last = PS_W'(prescale_div(int'(sel)) - 32'd1);
  assign pre_wrap = (pre_q == pre_last);
  assign done     = run && pre_wrap && (cnt_q == '1);
  assign is_zero  = (pre_q == '0) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (pre_wrap) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import stby_pkg::*;
#(
  parameter int SEL_W       = 3,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       sleep_req,
  input  logic       nmi_pin,
  input  logic       ext_pin,
  output logic       clk_en,
  output logic       osc_en,
  output logic       nap_pulse,
  output logic       wake_irq,
  output logic       wake_src
);

  localparam int N_PINS  = 2;
  localparam int PIN_NMI = 0;
  localparam int PIN_EXT = 1;

  // configuration registers
  logic             stby_en;
  logic             nmi_sel;
  ext_mode_e        ext_mode;
  logic [SEL_W-1:0] cks;
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata[7:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_en  <= 1'b0;
      nmi_sel  <= 1'b0;
      ext_mode <= EXT_LEVEL;
      cks      <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        ADDR_CTRL:  stby_en <= cfg_wdata[0];
        ADDR_EDGE: begin
          nmi_sel  <= cfg_wdata[0];
          ext_mode <= ext_mode_e'(cfg_wdata[2:1]);
        end
        ADDR_TIMER: cks <= cfg_wdata[SEL_W-1:0];
        default: ;
      endcase
    end
  end

  // named internal events
  stby_state_e state_q, state_d;
  logic        in_run, in_enter, in_standby, in_stab;
  logic        enter_go;
  logic        nmi_hit, ext_hit, wake_hit, wake_from_ext;
  logic        stab_done, cnt_zero;
  logic [N_PINS-1:0] pin_rise, pin_fall;

  assign in_run     = (state_q == ST_RUN);
  assign in_enter   = (state_q == ST_ENTER);
  assign in_standby = (state_q == ST_STANDBY);
  assign in_stab    = (state_q == ST_STAB);
  assign enter_go   = in_run && sleep_req && stby_en;

  stby_pin_sync #(
    .N_PINS      (N_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i ({ext_pin, nmi_pin}),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  stby_wake_qual i_qual (
    .armed         (in_standby),
    .nmi_sel       (nmi_sel),
    .nmi_rise      (pin_rise[PIN_NMI]),
    .nmi_fall      (pin_fall[PIN_NMI]),
    .ext_mode      (ext_mode),
    .ext_rise      (pin_rise[PIN_EXT]),
    .ext_fall      (pin_fall[PIN_EXT]),
    .nmi_hit       (nmi_hit),
    .ext_hit       (ext_hit),
    .wake_hit      (wake_hit),
    .wake_from_ext (wake_from_ext)
  );

  stby_stab_timer #(
    .SEL_W (SEL_W),
    .CNT_W (CNT_W)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (in_enter || in_standby),
    .run     (in_stab),
    .sel     (cks),
    .done    (stab_done),
    .is_zero (cnt_zero)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:     if (enter_go)  state_d = ST_ENTER;
      ST_ENTER:                  state_d = ST_STANDBY;
      ST_STANDBY: if (wake_hit)  state_d = ST_STAB;
      ST_STAB:    if (stab_done) state_d = ST_RUN;
      default:                   state_d = ST_RUN;
    endcase
  end

  logic nap_q, irq_q, src_pend_q, src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      nap_q      <= 1'b0;
      irq_q      <= 1'b0;
      src_pend_q <= 1'b0;
      src_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      nap_q   <= in_run && sleep_req && !stby_en;
      irq_q   <= stab_done;
      if (in_standby && wake_hit) src_pend_q <= wake_from_ext;
      if (stab_done)              src_q      <= src_pend_q;
    end
  end

  assign clk_en    = in_run;
  assign osc_en    = !in_standby;
  assign nap_pulse = nap_q;
  assign wake_irq  = irq_q;
  assign wake_src  = src_q;

endmodule

// File: rtl/stby_checker.sv
module stby_checker
  import stby_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_req,
  input logic             stby_en,
  input logic [1:0]       ext_mode,
  input logic [SEL_W-1:0] cks,
  input logic             clk_en,
  input logic             osc_en,
  input logic             nap_pulse,
  input logic             wake_irq,
  input logic             in_run,
  input logic             in_standby,
  input logic             in_stab,
  input logic             nmi_hit,
  input logic             wake_hit,
  input logic             stab_done,
  input logic             cnt_zero
);

  logic [31:0] age_q;
  int unsigned stab_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       age_q <= '0;
    else if (in_stab) age_q <= age_q + 32'd1;
    else              age_q <= '0;
  end

  always_comb stab_len = stab_cycles(int'(cks), CNT_W) - 32'd1;

  a_r2_gate_then_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req && stby_en) |=> (!clk_en && osc_en) ##1 !osc_en);

  a_r3_nap_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
    nap_pulse |-> (clk_en && osc_en));

  a_r4_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && !wake_hit) |=> in_standby);

  a_r5_level_never_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && ext_mode == 2'b00 && !nmi_hit) |=> !osc_en);

  a_r6_osc_on_at_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_standby && wake_hit) |=> (osc_en && !clk_en));

  a_r7_stab_length: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |-> (age_q == stab_len));

  a_r7_gated_in_stab: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stab && !stab_done) |=> !clk_en);

  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  a_r8_irq_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> clk_en);

  a_r9_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    in_standby |-> cnt_zero);

endmodule

bind standby_ctrl stby_checker #(
  .SEL_W (SEL_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep_req  (sleep_req),
  .stby_en    (stby_en),
  .ext_mode   (ext_mode),
  .cks        (cks),
  .clk_en     (clk_en),
  .osc_en     (osc_en),
  .nap_pulse  (nap_pulse),
  .wake_irq   (wake_irq),
  .in_run     (in_run),
  .in_standby (in_standby),
  .in_stab    (in_stab),
  .nmi_hit    (nmi_hit),
  .wake_hit   (wake_hit),
  .stab_done  (stab_done),
  .cnt_zero   (cnt_zero)
);

// File: tb/test_standby_ctrl.sv
`timescale 1ns/1ps
module test_standby_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       sleep_req = 1'b0;
  logic       nmi_pin = 1'b0;
  logic       ext_pin = 1'b0;
  logic       clk_en, osc_en, nap_pulse, wake_irq, wake_src;

  always #2.5 clk = ~clk;

  standby_ctrl i_standby_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sleep_req (sleep_req),
    .nmi_pin   (nmi_pin),
    .ext_pin   (ext_pin),
    .clk_en    (clk_en),
    .osc_en    (osc_en),
    .nap_pulse (nap_pulse),
    .wake_irq  (wake_irq),
    .wake_src  (wake_src)
  );

  int total = 0;
  int bad   = 0;

  typedef struct packed {
    logic       use_ext;
    logic       nmi_sel;
    logic [1:0] ext_mode;
    logic [2:0] cks;
    logic       lvl_start;
    logic       lvl_end;
    logic       wakes;
  } vec_t;

  // use_ext, nmi_sel, ext_mode, cks, start, end, wakes
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b1, 2'b00, 3'd0, 1'b0, 1'b1, 1'b1},  // R4 nmi rising
    '{1'b0, 1'b0, 2'b00, 3'd1, 1'b1, 1'b0, 1'b1},  // R4 nmi falling
    '{1'b0, 1'b1, 2'b00, 3'd0, 1'b1, 1'b0, 1'b0},  // R4 wrong nmi edge
    '{1'b1, 1'b1, 2'b01, 3'd0, 1'b1, 1'b0, 1'b1},  // R5 ext falling
    '{1'b1, 1'b1, 2'b10, 3'd2, 1'b0, 1'b1, 1'b1},  // R5 ext rising
    '{1'b1, 1'b1, 2'b11, 3'd0, 1'b0, 1'b1, 1'b1},  // R5 both, rise
    '{1'b1, 1'b1, 2'b11, 3'd0, 1'b1, 1'b0, 1'b1},  // R5 both, fall
    '{1'b1, 1'b1, 2'b00, 3'd0, 1'b1, 1'b0, 1'b0},  // R5 level mode
    '{1'b1, 1'b1, 2'b10, 3'd0, 1'b1, 1'b0, 1'b0}   // R5 wrong ext edge
  };

  function automatic int stab_len(input int sel);
    return 256 * (2 ** (sel + 1));
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic enter_standby();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    check("R2", "clk_en gated", 32'(clk_en), 32'd0);
    check("R2", "osc_en still on", 32'(osc_en), 32'd1);
    @(negedge clk);
    check("R2", "osc_en off", 32'(osc_en), 32'd0);
  endtask

  // called right after the qualifying pin change was driven
  task automatic wait_wake(input int sel, input logic src, input string len_tag);
    repeat (2) @(negedge clk);
    check("R6", "osc_en before sync", 32'(osc_en), 32'd0);
    @(negedge clk);
    check("R6", "osc_en on", 32'(osc_en), 32'd1);
    check("R6", "clk_en gated in stab", 32'(clk_en), 32'd0);
    repeat (stab_len(sel) - 1) @(negedge clk);
    check(len_tag, "clk_en still gated", 32'(clk_en), 32'd0);
    check("R7", "no early irq", 32'(wake_irq), 32'd0);
    @(negedge clk);
    check(len_tag, "clk_en back", 32'(clk_en), 32'd1);
    check("R8", "wake_irq", 32'(wake_irq), 32'd1);
    check("R8", "wake_src", 32'(wake_src), 32'(src));
    @(negedge clk);
    check("R8", "wake_irq one cycle", 32'(wake_irq), 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "clk_en", 32'(clk_en), 32'd1);
    check("R1", "osc_en", 32'(osc_en), 32'd1);
    check("R1", "wake_irq", 32'(wake_irq), 32'd0);
    check("R1", "nap_pulse", 32'(nap_pulse), 32'd0);

    // R3 ordinary sleep with standby enable at reset value 0
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    check("R3", "nap_pulse", 32'(nap_pulse), 32'd1);
    check("R3", "clk_en", 32'(clk_en), 32'd1);
    @(negedge clk);
    check("R3", "nap one cycle", 32'(nap_pulse), 32'd0);
    check("R3", "osc_en", 32'(osc_en), 32'd1);

    // R10 write to address 3 is ignored
    wr(2'd3, 8'hFF);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    check("R10", "addr3 no stby_en", 32'(nap_pulse), 32'd1);
    check("R10", "addr3 clk_en", 32'(clk_en), 32'd1);
    @(negedge clk);

    // vector table
    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      wr(2'd1, {5'd0, v.ext_mode, v.nmi_sel});
      wr(2'd2, {5'd0, v.cks});
      wr(2'd0, 8'd1);
      if (v.use_ext) begin
        ext_pin = v.lvl_start; nmi_pin = 1'b0;
      end else begin
        nmi_pin = v.lvl_start; ext_pin = 1'b0;
      end
      repeat (4) @(negedge clk);
      enter_standby();
      if (v.use_ext) ext_pin = v.lvl_end;
      else           nmi_pin = v.lvl_end;
      if (v.wakes) begin
        wait_wake(int'(v.cks), v.use_ext, "R7");
      end else begin
        repeat (8) @(negedge clk);
        check(v.use_ext ? "R5" : "R4", "no wake osc_en", 32'(osc_en), 32'd0);
        check(v.use_ext ? "R5" : "R4", "no wake clk_en", 32'(clk_en), 32'd0);
        nmi_pin = 1'b1;
        wait_wake(int'(v.cks), 1'b0, "R7");
        nmi_pin = 1'b0;
      end
      repeat (4) @(negedge clk);
    end

    // R11 edges while running do nothing
    wr(2'd1, {5'd0, 2'b11, 1'b1});
    for (int k = 0; k < 6; k++) begin
      nmi_pin = ~nmi_pin;
      ext_pin = ~ext_pin;
      repeat (2) @(negedge clk);
      check("R11", "wake_irq", 32'(wake_irq), 32'd0);
      check("R11", "clk_en", 32'(clk_en), 32'd1);
    end
    nmi_pin = 1'b0; ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R8 simultaneous wake: non-maskable pin wins
    wr(2'd2, 8'd0);
    enter_standby();
    nmi_pin = 1'b1; ext_pin = 1'b1;
    wait_wake(0, 1'b0, "R7");
    nmi_pin = 1'b0; ext_pin = 1'b0;
    repeat (4) @(negedge clk);

    // R9 back-to-back standby periods have the same length
    for (int k = 0; k < 2; k++) begin
      enter_standby();
      ext_pin = 1'b1;
      wait_wake(0, 1'b1, "R9");
      ext_pin = 1'b0;
      repeat (4) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule